// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block controls a bank of up to eight general-purpose pins. Each pin has its own 32-byte register window on a simple word-wide read/write bus. Through that window software enables the pin and picks its direction. It can also float the output driver, set the level that is driven, set a debounce threshold and read back the filtered input level. Each pin also has an event detector that can watch for a level, a single edge or both edges, with a polarity bit that picks which level or which edge.

An input level passes through a synchronizer and then a debounce counter before anything else sees it. The debounced level is what the input register reports, and it is the level the event detector samples. Pending events stay latched until software writes a one to the pin's clear register. A single status word shows the pending bit of every pin, and the bank raises one combined interrupt when any pending pin also has its interrupt enabled.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every register reads zero, no pin drives its pad (pad_oe all zero) and irq is low.
- R2: Offset 0x00 (config) reads back bit 0 enable, bit 1 output direction, bits 3:2 trigger kind, bit 4 polarity and bit 6 interrupt enable, with all other bits zero. Offset 0x04 reads back the 8-bit debounce threshold, offset 0x0C the float bit (bit 0) and offset 0x10 the drive level (bit 0). Offset 0x14 reads zero. Pin n's window begins at n×0x20.
- R3: pad_oe of a pin is high exactly when the pin is enabled, set to output and not floated. pad_out always follows the stored drive level.
- R4: Bit 0 of offset 0x08 shows the pin level after a two-flop synchronizer. With a threshold of 0, a level that changes before clock edge 1 is visible on the bus after clock edge 3 and not after edge 2.
- R5: With a nonzero threshold T, a new input level is accepted only after it has differed from the accepted level for T consecutive cycles. Shorter pulses are discarded.
- R6: Trigger kind 2 latches on a rising edge when polarity is 1 and on a falling edge when polarity is 0. Trigger kind 0 latches nothing, and a disabled pin latches nothing.
- R7: Trigger kind 3 latches on both the rising and the falling edge.
- R8: Trigger kind 1 latches while the level equals the polarity (1 = high, 0 = low). A clear does not remove the pending bit while that level persists.
- R9: Writing 1 to bit 0 of offset 0x14 clears the pin's pending bit. Writing 0 there has no effect, and an event in the same cycle as a clear wins.
- R10: Offset 0x104 reports pin n's pending bit in bit n. irq is high exactly when some pending pin has interrupt enable set. Pending bits latch whether or not the interrupt is enabled.
- R11: Reads of unmapped or misaligned addresses (windows at or above the pin count, window offsets above 0x14, offsets 0x100 to 0x1FF other than 0x104) return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero when not reading |
| pad_in | input | NPINS | Levels at the pads |
| pad_out | output | NPINS | Drive levels |
| pad_oe | output | NPINS | Driver enables |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is the meeting of the detector's set and clear paths. A level-sensitive pin must stay pending through a clear while its level is active, and an edge pin must drop only on a clear written while no new edge arrives. The bench reaches this by holding the pad level steady through the clear write and then releasing it. It also sweeps every combination of pending pattern and interrupt-enable mask over a four-pin bank, so that the combined interrupt is checked against an expected value computed as a bitwise product.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

   typedef enum logic [1:0] {
      TRIG_OFF   = 2'd0,
      TRIG_LEVEL = 2'd1,
      TRIG_EDGE  = 2'd2,
      TRIG_BOTH  = 2'd3
   } trig_e;

   typedef struct packed {
      logic  irq_en;
      logic  pol;
      trig_e trig;
      logic  dir;
      logic  en;
   } pin_cfg_t;

   localparam int WIN_SHIFT = 5;
   localparam int PIDX_W    = 3;
   localparam int MAX_PINS  = 1 << PIDX_W;

   localparam logic [WIN_SHIFT-1:0] OFS_CFG = 5'h00;
   localparam logic [WIN_SHIFT-1:0] OFS_DEB = 5'h04;
   localparam logic [WIN_SHIFT-1:0] OFS_INP = 5'h08;
   localparam logic [WIN_SHIFT-1:0] OFS_FLT = 5'h0C;
   localparam logic [WIN_SHIFT-1:0] OFS_VAL = 5'h10;
   localparam logic [WIN_SHIFT-1:0] OFS_CLR = 5'h14;

   localparam int STAT_ADDR = 'h104;

endpackage

// File: rtl/pbk_in_filter.sv
module pbk_in_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_W       = 8,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   input  logic [DEB_W-1:0] thr,
   output logic             level
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
   end

   assign synced = sync_q[SYNC_STAGES-1];

   generate
      if (FILTER_EN) begin : g_deb
         logic [DEB_W-1:0] run_q;
         logic [DEB_W:0]   run_nx;
         logic             lvl_q;

         assign run_nx = {1'b0, run_q} + 1'b1;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               lvl_q <= 1'b0;
            end else if (thr == '0) begin
               run_q <= '0;
               lvl_q <= synced;
            end else if (synced == lvl_q) begin
               run_q <= '0;
            end else if (run_nx >= {1'b0, thr}) begin
               run_q <= '0;
               lvl_q <= synced;
            end else begin
               run_q <= run_nx[DEB_W-1:0];
            end
         end

         assign level = lvl_q;
      end else begin : g_nodeb
         logic lvl_q;
         logic unused_thr;
         assign unused_thr = ^thr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= synced;
         end
         assign level = lvl_q;
      end
   endgenerate

endmodule

// File: rtl/pbk_irq_detect.sv
module pbk_irq_detect
   import pbk_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  level,
   input  logic  pin_en,
   input  trig_e trig,
   input  logic  pol,
   input  logic  clr,
   output logic  pend
);

   logic prev_q;
   logic pend_q;
   logic rise;
   logic fall;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;

   always_comb begin
      unique case (trig)
         TRIG_LEVEL: hit = (level == pol);
         TRIG_EDGE:  hit = pol ? rise : fall;
         TRIG_BOTH:  hit = rise | fall;
         default:    hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pend_q <= 1'b0;
      else if (pin_en && hit) pend_q <= 1'b1;
      else if (clr)           pend_q <= 1'b0;
   end

   assign pend = pend_q;

endmodule

// File: rtl/pbk_pin.sv
module pbk_pin
   import pbk_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int DEB_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_stb,
   input  logic [WIN_SHIFT-1:0] ofs,
   input  logic [7:0]           wdata,
   input  logic                 pad_raw,
   output logic [DATA_W-1:0]    rdata,
   output logic                 pin_en,
   output logic                 irq_en,
   output logic                 pend,
   output logic                 clr_hit,
   output logic                 drv_oe,
   output logic                 drv_lvl
);

   pin_cfg_t         cfg_q;
   logic [DEB_W-1:0] thr_q;
   logic             flt_q;
   logic             val_q;
   logic             level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         thr_q <= '0;
         flt_q <= 1'b0;
         val_q <= 1'b0;
      end else if (wr_stb) begin
         unique case (ofs)
            OFS_CFG: cfg_q <= '{irq_en: wdata[6], pol: wdata[4],
                                trig: trig_e'(wdata[3:2]),
                                dir: wdata[1], en: wdata[0]};
            OFS_DEB: thr_q <= wdata[DEB_W-1:0];
            OFS_FLT: flt_q <= wdata[0];
            OFS_VAL: val_q <= wdata[0];
            default: ;
         endcase
      end
   end

   assign clr_hit = wr_stb && (ofs == OFS_CLR) && wdata[0];

   pbk_in_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .DEB_W       (DEB_W),
      .FILTER_EN   (FILTER_EN)
   ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (pad_raw),
      .thr   (thr_q),
      .level (level)
   );

   pbk_irq_detect u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .level  (level),
      .pin_en (cfg_q.en),
      .trig   (cfg_q.trig),
      .pol    (cfg_q.pol),
      .clr    (clr_hit),
      .pend   (pend)
   );

   always_comb begin
      rdata = '0;
      unique case (ofs)
         OFS_CFG: begin
            rdata[0]   = cfg_q.en;
            rdata[1]   = cfg_q.dir;
            rdata[3:2] = cfg_q.trig;
            rdata[4]   = cfg_q.pol;
            rdata[6]   = cfg_q.irq_en;
         end
         OFS_DEB: rdata[DEB_W-1:0] = thr_q;
         OFS_INP: rdata[0] = level;
         OFS_FLT: rdata[0] = flt_q;
         OFS_VAL: rdata[0] = val_q;
         default: ;
      endcase
   end

   assign pin_en  = cfg_q.en;
   assign irq_en  = cfg_q.irq_en;
   assign drv_oe  = cfg_q.en & cfg_q.dir & ~flt_q;
   assign drv_lvl = val_q;

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
   import pbk_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 9,
   parameter int DEB_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic              irq
);

   localparam int WIN_TOP = WIN_SHIFT + PIDX_W;

   generate
      if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
         $error("pinbank_ctrl: NPINS must lie in 1..8");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("pinbank_ctrl: DATA_W must be at least 8");
      end
      if (ADDR_W < WIN_TOP + 1) begin : g_bad_addr
         $error("pinbank_ctrl: ADDR_W too small for the status word");
      end
      if (DEB_W < 1 || DEB_W > 8) begin : g_bad_deb
         $error("pinbank_ctrl: DEB_W must lie in 1..8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pinbank_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                 word_ok;
   logic                 in_win;
   logic                 stat_hit;
   logic [PIDX_W-1:0]    pin_idx;
   logic [WIN_SHIFT-1:0] ofs;
   logic                 wr_any;
   logic                 rd_any;

   logic [DATA_W-1:0] pin_rd [NPINS];
   logic [NPINS-1:0]  en_v;
   logic [NPINS-1:0]  ie_v;
   logic [NPINS-1:0]  pend_v;
   logic [NPINS-1:0]  clr_v;
   logic [DATA_W-1:0] win_rd;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:8];

   assign word_ok  = (bus_addr[1:0] == 2'b00);
   assign in_win   = (bus_addr[ADDR_W-1:WIN_TOP] == '0);
   assign stat_hit = (bus_addr == ADDR_W'(STAT_ADDR));
   assign pin_idx  = bus_addr[WIN_TOP-1:WIN_SHIFT];
   assign ofs      = bus_addr[WIN_SHIFT-1:0];
   assign wr_any   = bus_sel & bus_we & word_ok & in_win;
   assign rd_any   = bus_sel & ~bus_we & word_ok;

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         logic sel_this;
         assign sel_this = wr_any && (pin_idx == PIDX_W'(i));

         pbk_pin #(
            .DATA_W      (DATA_W),
            .DEB_W       (DEB_W),
            .SYNC_STAGES (SYNC_STAGES),
            .FILTER_EN   (FILTER_EN)
         ) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (sel_this),
            .ofs     (ofs),
            .wdata   (bus_wdata[7:0]),
            .pad_raw (pad_in[i]),
            .rdata   (pin_rd[i]),
            .pin_en  (en_v[i]),
            .irq_en  (ie_v[i]),
            .pend    (pend_v[i]),
            .clr_hit (clr_v[i]),
            .drv_oe  (pad_oe[i]),
            .drv_lvl (pad_out[i])
         );
      end
   endgenerate

   always_comb begin
      win_rd = '0;
      for (int i = 0; i < NPINS; i++) begin
         if (pin_idx == PIDX_W'(i)) win_rd = pin_rd[i];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_any) begin
         if (in_win)        bus_rdata = win_rd;
         else if (stat_hit) bus_rdata = DATA_W'(pend_v);
      end
   end

   assign irq = |(pend_v & ie_v);

endmodule

// File: rtl/pbk_chk.sv
module pbk_chk #(
   parameter int NPINS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] pad_oe,
   input logic [NPINS-1:0] en_v,
   input logic [NPINS-1:0] pend_v,
   input logic [NPINS-1:0] clr_v,
   input logic             irq
);

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (pad_oe == '0) && !irq);

   // R10
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend_v != '0));

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
         // R3
         oe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[i] |-> en_v[i]);

         // R6
         latch_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_v[i]) |-> $past(en_v[i]));

         // R9
         drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend_v[i]) |-> $past(clr_v[i]));
      end
   endgenerate

endmodule

bind pinbank_ctrl pbk_chk #(.NPINS(NPINS)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .pad_oe (pad_oe),
   .en_v   (en_v),
   .pend_v (pend_v),
   .clr_v  (clr_v),
   .irq    (irq)
);

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;

   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0;
   logic          we = 1'b0;
   logic [8:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NP-1:0] ext = '0;
   logic [NP-1:0] pad_in;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;
   logic          irq;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

   pinbank_ctrl #(.NPINS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .irq(irq)
   );

   function automatic logic [8:0] wa(input int p, input int o);
      return 9'(p * 32 + o);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; we = 1'b0; addr = a;
      #1 d = rdata;
      sel = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic clear_all();
      for (int p = 0; p < NP; p++) wr(wa(p, 'h14), 32'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int p = 0; p < NP; p++)
         for (int o = 0; o <= 'h14; o += 4) begin
            rd(wa(p, o), v);
            check("R1 reg", v, 0);
         end
      rd(9'h104, v); check("R1 status", v, 0);
      check("R1 pad_oe", 32'(pad_oe), 0);
      check("R1 irq", 32'(irq), 0);

      // R2 readback masks per pin
      for (int p = 0; p < NP; p++) begin
         wr(wa(p, 'h00), 32'hFFFF_FFFF); rd(wa(p, 'h00), v); check("R2 cfg", v, 32'h5F);
         wr(wa(p, 'h04), 32'hFFFF_FF00 | 32'(p + 3)); rd(wa(p, 'h04), v); check("R2 deb", v, 32'(p + 3));
         wr(wa(p, 'h0C), 32'hFFFF_FFFF); rd(wa(p, 'h0C), v); check("R2 float", v, 1);
         wr(wa(p, 'h10), 32'hFFFF_FFFE); rd(wa(p, 'h10), v); check("R2 value", v, 0);
         rd(wa(p, 'h14), v); check("R2 clear reads zero", v, 0);
      end
      for (int p = 0; p < NP; p++) begin
         wr(wa(p, 'h00), 0); wr(wa(p, 'h04), 0); wr(wa(p, 'h0C), 0); wr(wa(p, 'h10), 0);
      end
      clear_all();
      rd(9'h104, v); check("R9 cleared after R2", v, 0);

      // R3 drive sweep on pin 0
      for (int c = 0; c < 16; c++) begin
         wr(wa(0, 'h00), 32'(c & 3));
         wr(wa(0, 'h0C), 32'((c >> 2) & 1));
         wr(wa(0, 'h10), 32'((c >> 3) & 1));
         check("R3 oe", 32'(pad_oe[0]), 32'((c & 1) & ((c >> 1) & 1) & (((c >> 2) & 1) ^ 1)));
         check("R3 out", 32'(pad_out[0]), 32'((c >> 3) & 1));
      end
      wr(wa(0, 'h00), 0); wr(wa(0, 'h10), 0);

      // R4 input latency with zero threshold on pin 1
      wr(wa(1, 'h00), 32'h1);
      @(negedge clk); ext[1] = 1'b1;
      @(posedge clk); @(posedge clk);
      rd(wa(1, 'h08), v); check("R4 not yet after edge 2", v, 0);
      rd(wa(1, 'h08), v); check("R4 visible after edge 3", v, 1);

      // R5 debounce threshold 6 on pin 1
      wr(wa(1, 'h04), 32'd6);
      @(negedge clk); ext[1] = 1'b0;
      repeat (20) @(negedge clk);
      rd(wa(1, 'h08), v); check("R5 accepted low", v, 0);
      ext[1] = 1'b1; repeat (3) @(negedge clk); ext[1] = 1'b0;
      repeat (20) @(negedge clk);
      rd(wa(1, 'h08), v); check("R5 short pulse discarded", v, 0);
      ext[1] = 1'b1; repeat (20) @(negedge clk);
      rd(wa(1, 'h08), v); check("R5 stable level accepted", v, 1);
      ext[1] = 1'b0; repeat (20) @(negedge clk);
      wr(wa(1, 'h04), 0); wr(wa(1, 'h00), 0);

      // R6 single edge, pin 2
      wr(wa(2, 'h00), 32'h59);
      ext[2] = 1'b1; settle();
      rd(9'h104, v); check("R6 rising latched", v, 32'h4);
      check("R10 irq on rise", 32'(irq), 1);
      wr(wa(2, 'h14), 1); rd(9'h104, v); check("R9 clear", v, 0);
      ext[2] = 1'b0; settle();
      rd(9'h104, v); check("R6 falling ignored with pol 1", v, 0);
      wr(wa(2, 'h00), 32'h49);
      ext[2] = 1'b1; settle();
      rd(9'h104, v); check("R6 rising ignored with pol 0", v, 0);
      ext[2] = 1'b0; settle();
      rd(9'h104, v); check("R6 falling latched", v, 32'h4);
      // R9 writing zero leaves pending
      wr(wa(2, 'h14), 0); rd(9'h104, v); check("R9 zero write no effect", v, 32'h4);
      wr(wa(2, 'h14), 1);
      wr(wa(2, 'h00), 32'h58);
      ext[2] = 1'b1; settle(); ext[2] = 1'b0; settle();
      rd(9'h104, v); check("R6 disabled pin no latch", v, 0);
      wr(wa(2, 'h00), 32'h51);
      ext[2] = 1'b1; settle(); ext[2] = 1'b0; settle();
      rd(9'h104, v); check("R6 kind 0 no latch", v, 0);

      // R7 both edges
      wr(wa(2, 'h00), 32'h4D);
      ext[2] = 1'b1; settle();
      rd(9'h104, v); check("R7 rise", v, 32'h4);
      wr(wa(2, 'h14), 1); rd(9'h104, v); check("R7 cleared", v, 0);
      ext[2] = 1'b0; settle();
      rd(9'h104, v); check("R7 fall", v, 32'h4);
      wr(wa(2, 'h14), 1);

      // R8 level sensing
      wr(wa(2, 'h00), 32'h55);
      rd(9'h104, v); check("R8 inactive level", v, 0);
      ext[2] = 1'b1; settle();
      rd(9'h104, v); check("R8 high latched", v, 32'h4);
      wr(wa(2, 'h14), 1); rd(9'h104, v); check("R8 persists through clear", v, 32'h4);
      check("R8 irq held", 32'(irq), 1);
      ext[2] = 1'b0; settle();
      wr(wa(2, 'h14), 1); rd(9'h104, v); check("R8 clears when inactive", v, 0);
      wr(wa(2, 'h00), 32'h45); settle();
      rd(9'h104, v); check("R8 active low", v, 32'h4);
      wr(wa(2, 'h00), 0); wr(wa(2, 'h14), 1);

      // R10 sweep of pending pattern and enable mask
      for (int p = 0; p < NP; p++) wr(wa(p, 'h00), 32'h0D);
      for (int m = 0; m < 16; m++) begin
         ext = 4'(m); settle();
         rd(9'h104, v); check("R10 status pattern", v, 32'(m));
         check("R10 irq masked off", 32'(irq), 0);
         for (int e = 0; e < 16; e++) begin
            for (int p = 0; p < NP; p++) wr(wa(p, 'h00), 32'h0D | (32'((e >> p) & 1) << 6));
            check("R10 irq vs mask", 32'(irq), 32'((m & e) != 0));
         end
         for (int p = 0; p < NP; p++) wr(wa(p, 'h00), 32'h0D);
         ext = '0; settle(); clear_all();
         rd(9'h104, v); check("R10 swept clean", v, 0);
      end
      for (int p = 0; p < NP; p++) wr(wa(p, 'h00), 0);

      // R11 unmapped space
      wr(wa(5, 'h00), 32'h43); rd(wa(5, 'h00), v); check("R11 window beyond pins", v, 0);
      check("R11 no drive from unmapped write", 32'(pad_oe), 0);
      wr(9'h101, 32'h3); rd(wa(0, 'h00), v); check("R11 misaligned write ignored", v, 0);
      wr(wa(3, 'h18), 32'h1); rd(wa(3, 'h18), v); check("R11 offset 0x18", v, 0);
      wr(9'h104, 32'hF); rd(9'h104, v); check("R11 status write ignored", v, 0);
      rd(9'h100, v); check("R11 offset 0x100", v, 0);
      rd(9'h106, v); check("R11 misaligned read", v, 0);
      rd(9'h1FC, v); check("R11 top offset", v, 0);
      check("R11 irq idle", 32'(irq), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule